// File: doc/BRIEF.md
# Unibus I/O Instruction Address Former

This block turns one decoded I/O instruction into exactly one Unibus-style bus cycle. An instruction arrives with a direction (read or write), a form code, an 18-bit effective address and the data that the bus carries for writes. The general form takes one more step first. It reads one memory word at the effective address and takes the controller number and device address from that word. The two fast forms skip the memory read. Each one uses a fixed controller number and uses the effective address as the device address.

Each bus cycle is a plain single read or a single write. No byte lanes are used and no read-pause-write sequence is issued. A read returns a 16-bit value, which is zero-extended into a full word for the accumulator. A write sends the supplied data. A device that does not acknowledge, or that answers with a non-existent-memory indication, ends the instruction with an error and leaves the accumulator unwritten. The block reports busy from acceptance until completion and takes a new instruction only while idle.

Top module: `uio_addr_former`

## Requirements
- R1: For form code 2'b00 (general), the block raises `mem_req` with `mem_addr` equal to the accepted effective address and holds both until `mem_valid` is sampled. No bus cycle starts before that sample, and the bus request rises on the cycle after it.
- R2: In the general form, `bus_ctl` equals the fetched word bits [21:18] and `bus_addr` equals bits [17:0].
- R3: Form code 2'b01 drives `bus_ctl` = 3 and `bus_addr` = effective address on the cycle after acceptance, and raises no memory request.
- R4: Form code 2'b10 drives `bus_ctl` = 1 and `bus_addr` = effective address on the cycle after acceptance, and raises no memory request.
- R5: Form code 2'b11 is reserved. It completes on the cycle after acceptance with `done` and `error` high, and raises no memory request and no bus request.
- R6: `bus_write` is 1 for a write instruction (`instr_write` = 1) and 0 for a read. For a write, `bus_wdata` equals the accepted `instr_wdata`.
- R7: Once raised, `bus_req` stays high, with `bus_ctl`, `bus_addr`, `bus_write` and `bus_wdata` unchanged, until a response ends the cycle. Each instruction produces at most one bus cycle, and `bus_req` and `mem_req` are never high together.
- R8: A read that is acknowledged ends with a one-cycle `done` and `ac_we`, with `ac_wdata` = {20'b0, `bus_rdata`}. An acknowledged write ends with `done` and without `ac_we`.
- R9: `bus_nxm` sampled during a bus cycle ends it on the next cycle with `done` and `error` and without `ac_we`. This holds even when `bus_ack` is high at the same time.
- R10: If neither response arrives within TIMEOUT_CYCLES cycles of `bus_req`, the cycle ends with `done` and `error` and without `ac_we`. A response sampled in the last of those cycles still counts.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle, and is low the cycle after `done`. `instr_ready` is high exactly when `busy` is low. `instr_valid` while busy starts nothing. After reset the block is idle with no requests and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block idle, instruction taken when valid |
| instr_write | input | 1 | 1 = write to device, 0 = read into accumulator |
| instr_form | input | 2 | 00 general, 01 fast controller 3, 10 fast controller 1, 11 reserved |
| instr_ea | input | 18 | Effective address |
| instr_wdata | input | 16 | Accumulator bits carried by a write |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Address word read request |
| mem_addr | output | 18 | Address of the address word |
| mem_valid | input | 1 | Address word valid strobe |
| mem_rdata | input | 22 | Controller [21:18] and device address [17:0] of the fetched word |
| bus_req | output | 1 | Bus cycle request |
| bus_ctl | output | 4 | Controller number |
| bus_addr | output | 18 | Device address |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Device acknowledge |
| bus_nxm | input | 1 | No-device response |
| bus_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion with failure, valid with done |
| ac_we | output | 1 | Accumulator write strobe |
| ac_wdata | output | 36 | Zero-extended read data |

## Verification
The hardest situations to reach are the limits of the response window. One is an acknowledge that arrives in the very last cycle before the timeout, and another is an acknowledge and a no-device response in the same cycle. The bench has a responder model that counts request cycles and answers after a chosen delay. It sweeps that delay up to one less than the window and also runs it with no answer at all, for every form and direction. A separate run keeps `instr_valid` high for the whole instruction to show that nothing else starts while the block is busy.

// File: rtl/uio_pkg.sv
package uio_pkg;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 18;
    localparam int CTL_W  = 4;
    localparam int BUS_DW = 16;
    localparam int AW_W   = CTL_W + ADDR_W;

    typedef enum logic [1:0] {
        FORM_GEN  = 2'b00,
        FORM_FA   = 2'b01,
        FORM_FB   = 2'b10,
        FORM_RSVD = 2'b11
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_BUS   = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [ADDR_W-1:0] addr;
    } target_t;

    typedef struct packed {
        logic             fetch;
        logic             illegal;
        logic [CTL_W-1:0] fixed_ctl;
    } decode_t;

    function automatic target_t split_word(input logic [AW_W-1:0] w);
        target_t t;
        t.ctl  = w[AW_W-1:ADDR_W];
        t.addr = w[ADDR_W-1:0];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [BUS_DW-1:0] d);
        return {{(WORD_W-BUS_DW){1'b0}}, d};
    endfunction
endpackage

// File: rtl/uio_form_decode.sv
module uio_form_decode
    import uio_pkg::*;
#(
    parameter logic [CTL_W-1:0] FAST_A_CTL = 4'd3,
    parameter logic [CTL_W-1:0] FAST_B_CTL = 4'd1
) (
    input  logic [1:0] form,
    output decode_t    dec
);
    always_comb begin
        dec = '{fetch: 1'b0, illegal: 1'b0, fixed_ctl: '0};
        case (form_e'(form))
            FORM_GEN:  dec.fetch     = 1'b1;
            FORM_FA:   dec.fixed_ctl = FAST_A_CTL;
            FORM_FB:   dec.fixed_ctl = FAST_B_CTL;
            default:   dec.illegal   = 1'b1;
        endcase
    end
endmodule

// File: rtl/uio_target_sel.sv
module uio_target_sel
    import uio_pkg::*;
(
    input  logic              use_word,
    input  logic [CTL_W-1:0]  fixed_ctl,
    input  logic [ADDR_W-1:0] ea,
    input  logic [AW_W-1:0]   addr_word,
    output target_t           tgt
);
    always_comb begin
        if (use_word) begin
            tgt = split_word(addr_word);
        end else begin
            tgt.ctl  = fixed_ctl;
            tgt.addr = ea;
        end
    end
endmodule

// File: rtl/uio_resp_timer.sv
module uio_resp_timer #(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = active && (cnt == LAST);
endmodule

// File: rtl/uio_addr_former.sv
module uio_addr_former
    import uio_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    parameter logic [CTL_W-1:0] FAST_A_CTL = 4'd3,
    parameter logic [CTL_W-1:0] FAST_B_CTL = 4'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic              instr_write,
    input  logic [1:0]        instr_form,
    input  logic [ADDR_W-1:0] instr_ea,
    input  logic [BUS_DW-1:0] instr_wdata,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [AW_W-1:0]   mem_rdata,
    output logic              bus_req,
    output logic [CTL_W-1:0]  bus_ctl,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_nxm,
    input  logic [BUS_DW-1:0] bus_rdata,
    output logic              done,
    output logic              error,
    output logic              ac_we,
    output logic [WORD_W-1:0] ac_wdata
);
    state_e            state;
    decode_t           dec;
    target_t           sel_tgt;
    target_t           tgt_q;
    logic [ADDR_W-1:0] ea_q;
    logic              write_q;
    logic [BUS_DW-1:0] wdata_q;
    logic [BUS_DW-1:0] rdata_q;
    logic              err_q;
    logic              load_q;
    logic              expire;
    logic              accept;

    assign accept = instr_valid && (state == ST_IDLE);

    uio_form_decode #(
        .FAST_A_CTL(FAST_A_CTL),
        .FAST_B_CTL(FAST_B_CTL)
    ) u_dec (
        .form (instr_form),
        .dec  (dec)
    );

    uio_target_sel u_sel (
        .use_word  (state == ST_FETCH),
        .fixed_ctl (dec.fixed_ctl),
        .ea        (instr_ea),
        .addr_word (mem_rdata),
        .tgt       (sel_tgt)
    );

    uio_resp_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (state == ST_BUS),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tgt_q   <= '0;
            ea_q    <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ea_q    <= instr_ea;
                        write_q <= instr_write;
                        wdata_q <= instr_wdata;
                        err_q   <= 1'b0;
                        load_q  <= 1'b0;
                        if (dec.illegal) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else if (dec.fetch) begin
                            state <= ST_FETCH;
                        end else begin
                            tgt_q <= sel_tgt;
                            state <= ST_BUS;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        tgt_q <= sel_tgt;
                        state <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (bus_nxm) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (bus_ack) begin
                        load_q  <= !write_q;
                        rdata_q <= bus_rdata;
                        state   <= ST_DONE;
                    end else if (expire) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: begin
                    err_q  <= 1'b0;
                    load_q <= 1'b0;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    assign instr_ready = (state == ST_IDLE);
    assign busy        = (state != ST_IDLE);
    assign mem_req     = (state == ST_FETCH);
    assign mem_addr    = ea_q;
    assign bus_req     = (state == ST_BUS);
    assign bus_ctl     = tgt_q.ctl;
    assign bus_addr    = tgt_q.addr;
    assign bus_write   = write_q;
    assign bus_wdata   = wdata_q;
    assign done        = (state == ST_DONE);
    assign error       = done && err_q;
    assign ac_we       = done && load_q;
    assign ac_wdata    = widen(rdata_q);
endmodule

// File: rtl/uio_addr_former_chk.sv
module uio_addr_former_chk
    import uio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic              instr_ready,
    input logic [1:0]        instr_form,
    input logic [ADDR_W-1:0] instr_ea,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              bus_req,
    input logic [CTL_W-1:0]  bus_ctl,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              bus_nxm,
    input logic              done,
    input logic              error,
    input logic              ac_we,
    input logic [WORD_W-1:0] ac_wdata
);
    logic taken;
    assign taken = instr_valid && instr_ready;

    assert_fetch_hold_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && !bus_req);

    assert_fetch_to_bus_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_valid |=> bus_req && !mem_req);

    assert_fast_a_R3: assert property (@(posedge clk) disable iff (rst)
        taken && instr_form == 2'b01 |=> bus_req && !mem_req && bus_ctl == 4'd3 && bus_addr == $past(instr_ea));

    assert_fast_b_R4: assert property (@(posedge clk) disable iff (rst)
        taken && instr_form == 2'b10 |=> bus_req && !mem_req && bus_ctl == 4'd1 && bus_addr == $past(instr_ea));

    assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        taken && instr_form == 2'b11 |=> done && error && !bus_req && !mem_req);

    assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack && !bus_nxm |=>
            (bus_req && $stable(bus_ctl) && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))
            || (done && error));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && mem_req));

    assert_ac_load_R8: assert property (@(posedge clk) disable iff (rst)
        ac_we |-> done && !error && ac_wdata[WORD_W-1:BUS_DW] == '0);

    assert_nxm_R9: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_nxm |=> done && error && !ac_we);

    assert_error_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        error |-> done && !ac_we);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
        taken |=> busy);
endmodule

bind uio_addr_former uio_addr_former_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_form  (instr_form),
    .instr_ea    (instr_ea),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .bus_req     (bus_req),
    .bus_ctl     (bus_ctl),
    .bus_addr    (bus_addr),
    .bus_write   (bus_write),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .bus_nxm     (bus_nxm),
    .done        (done),
    .error       (error),
    .ac_we       (ac_we),
    .ac_wdata    (ac_wdata)
);

// File: tb/uio_addr_former_tb.sv
module uio_addr_former_tb;
    import uio_pkg::*;

    localparam int T = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              instr_valid = 1'b0;
    logic              instr_ready;
    logic              instr_write = 1'b0;
    logic [1:0]        instr_form = 2'b00;
    logic [ADDR_W-1:0] instr_ea = '0;
    logic [BUS_DW-1:0] instr_wdata = '0;
    logic              busy;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [AW_W-1:0]   mem_rdata = '0;
    logic              bus_req;
    logic [CTL_W-1:0]  bus_ctl;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_write;
    logic [BUS_DW-1:0] bus_wdata;
    logic              bus_ack = 1'b0;
    logic              bus_nxm = 1'b0;
    logic [BUS_DW-1:0] bus_rdata = '0;
    logic              done;
    logic              error;
    logic              ac_we;
    logic [WORD_W-1:0] ac_wdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    uio_addr_former #(.TIMEOUT_CYCLES(T)) u_dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    // observations from one instruction
    int n_mem, n_bus, n_done, n_acwe, n_rdybad, n_unstable, n_overlap, n_after_done;
    logic [ADDR_W-1:0] o_maddr;
    logic [CTL_W-1:0]  o_ctl;
    logic [ADDR_W-1:0] o_addr;
    logic              o_write;
    logic [BUS_DW-1:0] o_wdata;
    logic              o_err;
    logic [WORD_W-1:0] o_acdata;
    logic              o_idle_after;

    task automatic run_op(input logic [1:0] form, input bit wr, input logic [ADDR_W-1:0] ea,
                          input logic [BUS_DW-1:0] wd, input logic [AW_W-1:0] mw,
                          input int mdly, input int bdly, input int resp,
                          input logic [BUS_DW-1:0] rd, input bit hold);
        int guard = 0;
        n_mem = 0; n_bus = 0; n_done = 0; n_acwe = 0; n_rdybad = 0;
        n_unstable = 0; n_overlap = 0; n_after_done = 0;
        o_err = 1'b0; o_acdata = '0; o_maddr = '0;
        o_ctl = '0; o_addr = '0; o_write = 1'b0; o_wdata = '0;
        @(negedge clk);
        instr_valid = 1'b1; instr_form = form; instr_write = wr;
        instr_ea = ea; instr_wdata = wd;
        do begin
            @(negedge clk);
            guard++;
            if (hold) begin
                instr_ea    = ~ea;
                instr_form  = 2'b01;
                instr_wdata = ~wd;
            end else begin
                instr_valid = 1'b0;
            end
            if (busy && instr_ready) n_rdybad++;
            if (!busy) n_rdybad++;
            mem_valid = 1'b0;
            mem_rdata = ~mw;
            if (mem_req) begin
                n_mem++;
                if (n_mem == 1) o_maddr = mem_addr;
                else if (mem_addr != o_maddr) n_unstable++;
                if (n_mem > mdly) begin
                    mem_valid = 1'b1;
                    mem_rdata = mw;
                end
            end
            bus_ack = 1'b0; bus_nxm = 1'b0; bus_rdata = ~rd;
            if (bus_req) begin
                n_bus++;
                if (mem_req) n_overlap++;
                if (n_bus == 1) begin
                    o_ctl = bus_ctl; o_addr = bus_addr; o_write = bus_write; o_wdata = bus_wdata;
                end else if (bus_ctl != o_ctl || bus_addr != o_addr ||
                             bus_write != o_write || bus_wdata != o_wdata) begin
                    n_unstable++;
                end
                if (n_bus > bdly) begin
                    if (resp == 0 || resp == 3) begin bus_ack = 1'b1; bus_rdata = rd; end
                    if (resp == 1 || resp == 3) bus_nxm = 1'b1;
                end
            end
            if (ac_we) begin
                n_acwe++;
                o_acdata = ac_wdata;
            end
            if (done) begin
                n_done++;
                o_err = error;
                if (bus_req || mem_req) n_after_done++;
            end
        end while (!done && guard < 100);
        instr_valid = 1'b0;
        bus_ack = 1'b0; bus_nxm = 1'b0; mem_valid = 1'b0;
        @(negedge clk);
        o_idle_after = !busy && instr_ready && !done && !bus_req && !mem_req;
    endtask

    task automatic do_case(input logic [1:0] form, input bit wr, input logic [ADDR_W-1:0] ea,
                           input logic [BUS_DW-1:0] wd, input logic [AW_W-1:0] mw,
                           input int mdly, input int bdly, input int resp,
                           input logic [BUS_DW-1:0] rd);
        bit gen = (form == 2'b00);
        bit rsv = (form == 2'b11);
        bit exp_err;
        longint exp_ctl;
        longint exp_addr;
        run_op(form, wr, ea, wd, mw, mdly, bdly, resp, rd, 1'b0);
        exp_err  = rsv || (resp != 0);
        exp_ctl  = gen ? longint'(mw[21:18]) : (form == 2'b01 ? 3 : 1);
        exp_addr = gen ? longint'(mw[17:0]) : longint'(ea);
        chk(gen ? "R1" : (rsv ? "R5" : (form == 2'b01 ? "R3" : "R4")), "mem reads",
            n_mem, gen ? mdly + 1 : 0);
        if (gen) chk("R1", "mem addr", o_maddr, ea);
        if (rsv) begin
            chk("R5", "bus cycles", n_bus, 0);
        end else begin
            chk(gen ? "R2" : (form == 2'b01 ? "R3" : "R4"), "ctl", o_ctl, exp_ctl);
            chk(gen ? "R2" : (form == 2'b01 ? "R3" : "R4"), "addr", o_addr, exp_addr);
            chk("R6", "dir", o_write, wr);
            if (wr) chk("R6", "wdata", o_wdata, wd);
            chk(resp == 2 ? "R10" : "R7", "req cycles", n_bus,
                resp == 2 ? T : bdly + 1);
        end
        chk("R7", "stability/overlap", n_unstable + n_overlap + n_after_done, 0);
        chk(resp == 3 ? "R9" : (resp == 2 ? "R10" : "R8"), "error", o_err, exp_err);
        chk("R8", "ac writes", n_acwe, (!exp_err && !wr) ? 1 : 0);
        if (!exp_err && !wr) chk("R8", "ac data", o_acdata, {20'b0, rd});
        chk("R11", "done pulses", n_done, 1);
        chk("R11", "busy/ready", n_rdybad, 0);
        chk("R11", "idle after done", o_idle_after, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11", "reset idle", {busy, instr_ready, mem_req, bus_req, done, ac_we}, 6'b010000);

        for (int form = 0; form < 4; form++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    for (int resp = 0; resp < 4; resp++) begin
                        logic [ADDR_W-1:0] ea;
                        logic [AW_W-1:0]   mw;
                        ea = ADDR_W'(pat * 18'h0B5A3 + form * 18'h11 + wr);
                        if (pat == 3) ea = '1;
                        mw = {CTL_W'(pat * 5 + form), ea ^ 18'h15555};
                        do_case(2'(form), wr[0], ea, 16'(16'hA5C3 ^ (pat << 4) ^ form),
                                mw, pat % 3, (pat + resp) % 3, resp,
                                16'(16'h8001 + pat * 16'h1234 + form));
                    end
                end
            end
        end

        // R10 boundary: acknowledge in the last cycle of the window succeeds
        do_case(2'b00, 1'b0, 18'h2F00F, 16'h0, 22'h3A_BCDE, 1, T - 1, 0, 16'hFFFF);
        do_case(2'b10, 1'b1, 18'h00001, 16'hFFFF, 22'h0, 0, T - 1, 0, 16'h0);

        // R11: instr_valid held high through a whole instruction starts nothing extra
        run_op(2'b10, 1'b1, 18'h12345, 16'h5A5A, 22'h0, 0, 2, 0, 16'h0, 1'b1);
        chk("R11", "held valid bus cycles", n_bus, 3);
        chk("R11", "held valid addr", o_addr, 18'h12345);
        chk("R11", "held valid ctl", o_ctl, 1);
        chk("R11", "held valid data", o_wdata, 16'h5A5A);
        chk("R11", "held valid done", n_done, 1);

        finish_run();
    end
endmodule